// File: doc/BRIEF.md
# ADC Trigger and Acquisition Sequencer

This block decides when an analog-to-digital conversion starts and steps it through its phases. A conversion can be requested by software, or by one of four hardware events: a capture/compare match, a charge-time measurement event, a timer event or a real-time clock event. Two of these events must first be qualified by their own mode or enable settings. Every request is gated by the module enable. An accepted request raises the busy flag. The block then waits out an acquisition window and runs a fixed-length conversion phase. Both phases are timed in conversion-clock ticks, which arrive as a clock-enable input.

When the acquisition code is zero, the user times the acquisition. The conversion then begins at the next instruction-cycle strobe instead of after a counted window. A stand-in converter supplies the value that is stored at completion. The capture/compare event also clears the associated timers, so that sampling repeats periodically. This clear happens even while the converter is disabled.

Top module: `adc_trig_seq`

## Requirements
- R1: A capture/compare event starts a conversion only while `cmp_mode_i` equals 4'b1011; with any other mode it has no effect on `busy_o`.
- R2: A charge-time event starts a conversion only while `ctm_trig_en_i` is 1.
- R3: A timer event, a real-time clock event or `sw_start_i` starts a conversion with no further qualification; `busy_o` is 1 in the cycle after the request.
- R4: While `en_i` is 0, every request is ignored and `busy_o` stays 0.
- R5: A capture/compare event sampled while the mode is 4'b1011 gives a one-cycle `timer_clr_o` pulse in the next cycle, whatever the value of `en_i`.
- R6: With a nonzero acquisition code, acquisition lasts 2, 4, 6, 8, 12, 16 or 20 conversion ticks for codes 1 to 7. It is followed by RES_W+1 conversion ticks (13 for a 12-bit result). `busy_o` stays 1 throughout.
- R7: With acquisition code 3'b000, an accepted request waits for the next `instr_ce_i` strobe after the start cycle, and only then begins the conversion phase.
- R8: On the final conversion tick, `result_o` takes the value of `stub_val_i` at that edge, `busy_o` falls, and `done_o` pulses for exactly one cycle.
- R9: A request that arrives while `busy_o` is 1 neither restarts nor extends the sequence under way.
- R10: Clearing `en_i` during a sequence aborts it: `busy_o` falls in the next cycle, no `done_o` pulse follows, and `result_o` keeps its value.
- R11: After reset, `busy_o`, `done_o` and `timer_clr_o` are 0 and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| conv_ce_i | input | 1 | Conversion-clock tick |
| instr_ce_i | input | 1 | Instruction-cycle strobe |
| acq_code_i | input | 3 | Acquisition time select |
| sw_start_i | input | 1 | Software start request |
| cmp_evt_i | input | 1 | Capture/compare event |
| cmp_mode_i | input | 4 | Capture/compare mode field |
| ctm_evt_i | input | 1 | Charge-time unit event |
| ctm_trig_en_i | input | 1 | Charge-time trigger enable |
| tmr_evt_i | input | 1 | Timer event |
| rtc_evt_i | input | 1 | Real-time clock event |
| stub_val_i | input | RES_W | Value returned by the stand-in converter |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timer_clr_o | output | 1 | One-cycle clear to the compare timers |
| result_o | output | RES_W | Result register |

## Verification
The bench builds the block with its default RES_W of 12, so every conversion phase runs the full 13 ticks. The conversion tick is divided by three and the instruction strobe by four. With these settings, all seven acquisition lengths and the deferred zero-code start fit into short runs. Because the stub value changes every cycle, a capture one edge early or late shows up as a wrong result. A per-clock reference model compares every output. It covers aborts in both phases and requests arriving during a busy period.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_HOLD, ST_CONV} seq_state_e;

  localparam int ACQ_MAX = 20;
  localparam logic [3:0] CMP_TRIG_MODE = 4'b1011;

  // index of each qualified request inside the request vector
  localparam int SRC_CMP = 0;
  localparam int SRC_CTM = 1;
  localparam int SRC_TMR = 2;
  localparam int SRC_RTC = 3;
  localparam int N_SRC   = 4;

  function automatic int unsigned acq_ticks(input logic [2:0] code);
    case (code)
      3'd1:    return 2;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 12;
      3'd6:    return 16;
      3'd7:    return ACQ_MAX;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/adc_trig_qual.sv
module adc_trig_qual
  import adc_seq_pkg::*;
#(
  parameter logic [3:0] CMP_MODE = CMP_TRIG_MODE
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmp_evt_i,
  input  logic [3:0] cmp_mode_i,
  input  logic       ctm_evt_i,
  input  logic       ctm_trig_en_i,
  input  logic       tmr_evt_i,
  input  logic       rtc_evt_i,
  output logic       hw_req_o,
  output logic       timer_clr_o
);
  logic [N_SRC-1:0] req_vec;
  logic             cmp_ok;

  assign cmp_ok           = cmp_evt_i && (cmp_mode_i == CMP_MODE);
  assign req_vec[SRC_CMP] = cmp_ok;
  assign req_vec[SRC_CTM] = ctm_evt_i && ctm_trig_en_i;
  assign req_vec[SRC_TMR] = tmr_evt_i;
  assign req_vec[SRC_RTC] = rtc_evt_i;
  assign hw_req_o         = |req_vec;

  // timer clear is independent of module enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) timer_clr_o <= 1'b0;
    else         timer_clr_o <= cmp_ok;
  end

  a_r5_clr_follows_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_evt_i && cmp_mode_i == CMP_MODE) |=> timer_clr_o);
  a_r5_clr_needs_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i != CMP_MODE) |=> !timer_clr_o);
endmodule

// File: rtl/adc_tick_cnt.sv
module adc_tick_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             ce_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = ce_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= load_val_i;
    else if (ce_i && cnt_q != '0)         cnt_q <= cnt_q - CNT_W'(1);
  end

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && ce_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W      = 5,
  parameter int CONV_TICKS = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_req_i,
  input  logic [2:0]       acq_code_i,
  input  logic             conv_ce_i,
  input  logic             instr_ce_i,
  input  logic             cnt_last_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             cnt_ce_o,
  output logic             cap_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e state_q, state_d;
  logic       start, abort;

  assign busy_o   = (state_q != ST_IDLE);
  assign start    = (state_q == ST_IDLE) && en_i && start_req_i;
  assign abort    = busy_o && !en_i;
  assign cnt_ce_o = conv_ce_i && (state_q == ST_ACQ || state_q == ST_CONV);

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = CNT_W'(CONV_TICKS);
    cap_o      = 1'b0;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          if (acq_code_i == 3'b000) begin
            state_d = ST_HOLD;
          end else begin
            state_d    = ST_ACQ;
            cnt_load_o = 1'b1;
            cnt_val_o  = CNT_W'(acq_ticks(acq_code_i));
          end
        end
        ST_ACQ: if (cnt_last_i) begin
          state_d    = ST_CONV;
          cnt_load_o = 1'b1;
        end
        ST_HOLD: if (instr_ce_i) begin
          state_d    = ST_CONV;
          cnt_load_o = 1'b1;
        end
        ST_CONV: if (cnt_last_i) begin
          state_d = ST_IDLE;
          cap_o   = 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= cap_o;
    end
  end

  a_r4_disabled_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !busy_o) |=> !busy_o);
  a_r8_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r10_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !en_i) |=> (!busy_o && !done_o));
  a_r9_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && en_i && !cnt_last_i) |=> busy_o);
  a_r7_hold_waits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && en_i && !instr_ce_i) |=> state_q == ST_HOLD);
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [RES_W-1:0] d_i,
  output logic [RES_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end

  a_r10_hold_without_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             conv_ce_i,
  input  logic             instr_ce_i,
  input  logic [2:0]       acq_code_i,
  input  logic             sw_start_i,
  input  logic             cmp_evt_i,
  input  logic [3:0]       cmp_mode_i,
  input  logic             ctm_evt_i,
  input  logic             ctm_trig_en_i,
  input  logic             tmr_evt_i,
  input  logic             rtc_evt_i,
  input  logic [RES_W-1:0] stub_val_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             timer_clr_o,
  output logic [RES_W-1:0] result_o
);
  localparam int CONV_TICKS = RES_W + 1;
  localparam int CNT_MAX    = (CONV_TICKS > ACQ_MAX) ? CONV_TICKS : ACQ_MAX;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  logic             hw_req, cnt_load, cnt_ce, cnt_last, cap;
  logic [CNT_W-1:0] cnt_val;

  adc_trig_qual u_qual (
    .clk_i, .rst_ni, .cmp_evt_i, .cmp_mode_i, .ctm_evt_i, .ctm_trig_en_i,
    .tmr_evt_i, .rtc_evt_i, .hw_req_o(hw_req), .timer_clr_o
  );

  adc_seq_ctrl #(.CNT_W(CNT_W), .CONV_TICKS(CONV_TICKS)) u_ctrl (
    .clk_i, .rst_ni, .en_i, .start_req_i(hw_req || sw_start_i), .acq_code_i,
    .conv_ce_i, .instr_ce_i, .cnt_last_i(cnt_last), .cnt_load_o(cnt_load),
    .cnt_val_o(cnt_val), .cnt_ce_o(cnt_ce), .cap_o(cap), .busy_o, .done_o
  );

  adc_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(cnt_load), .load_val_i(cnt_val), .ce_i(cnt_ce),
    .last_o(cnt_last)
  );

  adc_result_reg #(.RES_W(RES_W)) u_res (
    .clk_i, .rst_ni, .cap_i(cap), .d_i(stub_val_i), .q_o(result_o)
  );
endmodule

// File: tb/adc_trig_seq_tb_top.sv
module adc_trig_seq_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 0, conv_ce = 0, instr_ce = 0, sw = 0, cmp = 0, ctm = 0, ctm_en = 0, tmr = 0, rtc = 0;
  logic [2:0]  code = 3'd1;
  logic [3:0]  mode = 4'b0000;
  logic [11:0] stub = 12'h000;
  logic        busy, done, tclr;
  logic [11:0] res;

  int errors = 0, checks = 0, cyc = 0, done_seen = 0;
  // reference model state: 0 idle, 1 acquire, 2 wait strobe, 3 convert
  int ms = 0, mc = 0;
  bit m_done = 0, m_clr = 0;
  logic [11:0] m_res = '0;

  always #10 clk = ~clk;

  adc_trig_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .conv_ce_i(conv_ce), .instr_ce_i(instr_ce),
    .acq_code_i(code), .sw_start_i(sw), .cmp_evt_i(cmp), .cmp_mode_i(mode),
    .ctm_evt_i(ctm), .ctm_trig_en_i(ctm_en), .tmr_evt_i(tmr), .rtc_evt_i(rtc),
    .stub_val_i(stub), .busy_o(busy), .done_o(done), .timer_clr_o(tclr), .result_o(res)
  );

  function automatic int acq_len(input logic [2:0] c);
    int t[8] = '{0, 2, 4, 6, 8, 12, 16, 20};
    return t[c];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // free-running strobes and stub value
  always @(posedge clk) begin
    cyc++;
    #1;
    conv_ce  = (cyc % 3 == 0);
    instr_ce = (cyc % 4 == 0);
    stub     = stub + 12'd7;
  end

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mc = 0; m_done = 0; m_clr = 0; m_res = '0;
    end else begin
      bit req;
      m_clr  = cmp && (mode == 4'b1011);
      m_done = 0;
      req = sw || tmr || rtc || (ctm && ctm_en) || m_clr;
      if (ms != 0 && !en) ms = 0;
      else case (ms)
        0: if (en && req) begin
             if (code == 3'd0) ms = 2;
             else begin ms = 1; mc = acq_len(code); end
           end
        1: if (conv_ce) begin
             if (mc == 1) begin ms = 3; mc = 13; end else mc--;
           end
        2: if (instr_ce) begin ms = 3; mc = 13; end
        3: if (conv_ce) begin
             if (mc == 1) begin ms = 0; m_done = 1; m_res = stub; end else mc--;
           end
        default: ms = 0;
      endcase
    end
  end

  // per-clock comparison
  always @(negedge clk) if (rst_n) begin
    check(busy == (ms != 0), "R6 busy", busy, ms != 0);
    check(done == m_done, "R8 done", done, m_done);
    check(res == m_res, "R8 result", res, m_res);
    check(tclr == m_clr, "R5 timer_clr", tclr, m_clr);
    if (done) done_seen++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic fire(input int which);
    @(posedge clk); #2;
    case (which)
      0: sw = 1; 1: cmp = 1; 2: ctm = 1; 3: tmr = 1; default: rtc = 1;
    endcase
    @(posedge clk); #2;
    sw = 0; cmp = 0; ctm = 0; tmr = 0; rtc = 0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && ms != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int d0;
    logic [11:0] r0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 0 && done == 0 && tclr == 0, "R11 ctrl reset", busy, 0);
    check(res == 0, "R11 result reset", res, 0);
    #2 rst_n = 1;
    @(posedge clk); #2 en = 1;

    // R3 timer, code 1
    code = 3'd1; fire(3);
    check(busy == 1, "R3 timer start", busy, 1);
    d0 = done_seen; wait_idle();
    check(done_seen == d0 + 1, "R3 completes", done_seen - d0, 1);

    // R1 compare with wrong mode, then correct mode
    mode = 4'b1010; fire(1);
    check(busy == 0, "R1 wrong mode", busy, 0);
    mode = 4'b1011; fire(1);
    check(busy == 1, "R1 mode 1011", busy, 1);
    wait_idle();

    // R2 charge-time without and with enable
    ctm_en = 0; fire(2);
    check(busy == 0, "R2 no enable", busy, 0);
    ctm_en = 1; fire(2);
    check(busy == 1, "R2 enabled", busy, 1);
    wait_idle();

    // R6 all acquisition lengths via rtc and software
    for (int c = 1; c < 8; c++) begin
      code = 3'(c); fire((c % 2) ? 4 : 0);
      check(busy == 1, "R6 start", busy, 1);
      wait_idle();
    end

    // R7 zero code, deferred start
    code = 3'd0; d0 = done_seen; fire(0);
    check(busy == 1, "R7 hold start", busy, 1);
    wait_idle();
    check(done_seen == d0 + 1, "R7 completes", done_seen - d0, 1);

    // R9 requests during busy
    code = 3'd4; d0 = done_seen; fire(3);
    repeat (5) @(posedge clk);
    fire(4); fire(0); fire(3);
    wait_idle();
    check(done_seen == d0 + 1, "R9 single done", done_seen - d0, 1);

    // R4 disabled: nothing starts, clear pulse still comes (R5)
    en = 0; mode = 4'b1011;
    fire(1);
    check(tclr == 1, "R5 clr while disabled", tclr, 1);
    check(busy == 0, "R4 cmp ignored", busy, 0);
    fire(0); check(busy == 0, "R4 sw ignored", busy, 0);
    fire(3); check(busy == 0, "R4 timer ignored", busy, 0);
    @(posedge clk); #2 en = 1;

    // R10 abort during acquisition and during conversion
    r0 = res; d0 = done_seen;
    code = 3'd7; fire(3);
    repeat (10) @(posedge clk); #2 en = 0;
    @(posedge clk); @(negedge clk);
    check(busy == 0, "R10 abort acq", busy, 0);
    #2 en = 1;
    code = 3'd1; fire(4);
    repeat (20) @(posedge clk); #2 en = 0;
    @(posedge clk); @(negedge clk);
    check(busy == 0, "R10 abort conv", busy, 0);
    repeat (5) @(negedge clk);
    check(res == r0, "R10 result kept", res, r0);
    check(done_seen == d0, "R10 no done", done_seen - d0, 0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule